// File: doc/BRIEF.md
# Two-step egress timestamp queue

This block queues the egress timestamps that a switch produces for frames sent in two-step precision-time mode, so that a slower consumer can collect them later. A producer writes one entry per push cycle. Each entry carries a transmit flag, an egress port number, a nanosecond stamp and an 8-bit sub-nanosecond byte. For every transmitted frame the producer writes two entries. The first is a transmit entry with the port and the egress nanoseconds. The second is a companion entry whose stamp and sub-nanosecond fields, joined together, form the identifier of the frame.

The consumer sees the oldest entry on a set of registered head outputs, along with a valid level and a sticky overflow flag. A one-cycle `next_i` strobe removes the head and shows the entry behind it. A one-cycle `ovf_clr_i` strobe clears the overflow flag, as a write of 1 would. `irq_o` stays high for as long as an entry is waiting. The block also outputs the frame identifier of the head entry, so the consumer does not have to join the two fields itself. The consumer builds the full egress time by comparing the nanosecond field with the current time of day.

Top module: `ts2_fifo_top`

## Requirements
- R1: After reset, `head_valid_o`, `head_ovf_o` and `irq_o` are 0, and every head field (`head_tx_o`, `head_port_o`, `head_nsec_o`, `head_subns_o`, `head_fid_o`) is 0.
- R2: A push is accepted when the queue holds fewer than DEPTH entries. If the queue was empty, the pushed entry appears on the head outputs, with `head_valid_o` = 1, right after the clock edge that takes the push. `head_valid_o` is 1 exactly when the queue holds at least one entry.
- R3: Entries leave in the order they were pushed. A `next_i` strobe on a non-empty queue removes the head, and the following entry (or the empty state) is shown right after the same edge.
- R4: A `next_i` strobe while the queue is empty has no effect: the queue stays empty and the flags do not change. If it comes together with a push, that push is still accepted and shown.
- R5: A push while the queue holds DEPTH entries and no `next_i` is given in the same cycle is dropped. The stored entries do not change, and `head_ovf_o` becomes 1 after that edge.
- R6: A push and a `next_i` in the same cycle on a full queue are both accepted: the head advances, the new entry goes to the tail, and no overflow is flagged.
- R7: `head_ovf_o` stays at 1 until a cycle with `ovf_clr_i` = 1 clears it. When a dropped push and `ovf_clr_i` fall in the same cycle, the flag ends at 1.
- R8: `irq_o` equals `head_valid_o` in every cycle.
- R9: `head_fid_o` equals the low FID_W bits of (`head_nsec_o` shifted left by 8) OR `head_subns_o`.
- R10: While `head_valid_o` = 1, the head fields carry, without change, the transmit flag, port, nanoseconds and sub-nanosecond byte of the oldest entry. While it is 0, all of them are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Producer writes one entry this cycle |
| push_tx_i | input | 1 | Transmit flag of the pushed entry |
| push_port_i | input | TS2_PORT_W (7) | Egress port of the pushed entry |
| push_nsec_i | input | TS2_NS_W (30) | Nanosecond stamp or identifier high part |
| push_subns_i | input | TS2_SUB_W (8) | Sub-nanosecond byte or identifier low part |
| next_i | input | 1 | Pop strobe from the consumer |
| ovf_clr_i | input | 1 | Clear strobe for the overflow flag |
| head_valid_o | output | 1 | Head entry present |
| head_ovf_o | output | 1 | Sticky flag: at least one entry was lost |
| head_tx_o | output | 1 | Head transmit flag |
| head_port_o | output | TS2_PORT_W (7) | Head egress port |
| head_nsec_o | output | TS2_NS_W (30) | Head nanosecond field |
| head_subns_o | output | TS2_SUB_W (8) | Head sub-nanosecond byte |
| head_fid_o | output | FID_W (16) | Frame identifier joined from head stamp and byte |
| irq_o | output | 1 | Level request, high while an entry waits |

## Verification
Every result is due one clock edge after its stimulus. A push, a pop or a clear that the edge samples appears on the registered head outputs right after that edge, including the case of a push into an empty queue, which is forwarded straight to the head. The bench drives its inputs at the falling edge and lets one rising edge pass. It updates its reference queue at that rising edge and compares all outputs at the next falling edge, so each check lands exactly one edge after the stimulus.

// File: rtl/ts2_pkg.sv
package ts2_pkg;
    localparam int TS2_PORT_W = 7;
    localparam int TS2_NS_W   = 30;
    localparam int TS2_SUB_W  = 8;

    typedef struct packed {
        logic                  tx;
        logic [TS2_PORT_W-1:0] port;
        logic [TS2_NS_W-1:0]   nsec;
        logic [TS2_SUB_W-1:0]  subns;
    } ts2_ent_t;
endpackage

// File: rtl/ts2_store.sv
module ts2_store
    import ts2_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk_i,
    input  logic             we_i,
    input  logic [PTR_W-1:0] waddr_i,
    input  ts2_ent_t         wdata_i,
    input  logic [PTR_W-1:0] raddr_i,
    output ts2_ent_t         rdata_o
);
    ts2_ent_t mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ts2_ctrl.sv
module ts2_ctrl
    import ts2_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  ts2_ent_t         push_ent_i,
    input  logic             next_i,
    input  logic             ovf_clr_i,
    input  ts2_ent_t         rd_ent_i,
    output logic             we_o,
    output logic [PTR_W-1:0] waddr_o,
    output logic [PTR_W-1:0] raddr_o,
    output logic             valid_o,
    output logic             ovf_o,
    output ts2_ent_t         head_o
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             valid;
        ts2_ent_t         head;
    } state_t;

    state_t st_d, st_q;
    logic   full, pop_ok, push_ok;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        full    = (st_q.cnt == FULL_CNT);
        pop_ok  = next_i && (st_q.cnt != '0);
        push_ok = push_i && (!full || pop_ok);

        if (pop_ok)  st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
        if (push_ok) st_d.wr_ptr = ptr_inc(st_q.wr_ptr);
        st_d.cnt = st_q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);

        if (push_i && !push_ok)  st_d.ovf = 1'b1;
        else if (ovf_clr_i)      st_d.ovf = 1'b0;

        st_d.valid = (st_d.cnt != '0);
        st_d.head  = '0;
        if (st_d.valid) begin
            // a freshly written slot is not yet in storage: forward it
            st_d.head = (push_ok && st_d.rd_ptr == st_q.wr_ptr) ? push_ent_i : rd_ent_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign we_o    = push_ok;
    assign waddr_o = st_q.wr_ptr;
    assign raddr_o = st_d.rd_ptr;
    assign valid_o = st_q.valid;
    assign ovf_o   = st_q.ovf;
    assign head_o  = st_q.head;

    AST_VALID_MATCHES_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o == (st_q.cnt != '0)); // R2
    AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= FULL_CNT); // R5
    AST_DROP_SETS_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && st_q.cnt == FULL_CNT && !next_i) |=> ovf_o); // R5
    AST_DROP_KEEPS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && st_q.cnt == FULL_CNT && !next_i) |=> $stable(st_q.cnt)); // R5
    AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_o && !ovf_clr_i) |=> ovf_o); // R7
    AST_EMPTY_POP_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!valid_o && next_i && !push_i) |=> !valid_o); // R4
    AST_FULL_SWAP_NO_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && next_i && st_q.cnt == FULL_CNT && !ovf_o) |=> !ovf_o); // R6
    AST_EMPTY_HEAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> (head_o == '0)); // R10
endmodule

// File: rtl/ts2_fifo_top.sv
module ts2_fifo_top
    import ts2_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int FID_W = 16
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  push_i,
    input  logic                  push_tx_i,
    input  logic [TS2_PORT_W-1:0] push_port_i,
    input  logic [TS2_NS_W-1:0]   push_nsec_i,
    input  logic [TS2_SUB_W-1:0]  push_subns_i,
    input  logic                  next_i,
    input  logic                  ovf_clr_i,
    output logic                  head_valid_o,
    output logic                  head_ovf_o,
    output logic                  head_tx_o,
    output logic [TS2_PORT_W-1:0] head_port_o,
    output logic [TS2_NS_W-1:0]   head_nsec_o,
    output logic [TS2_SUB_W-1:0]  head_subns_o,
    output logic [FID_W-1:0]      head_fid_o,
    output logic                  irq_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int RAW_W = TS2_NS_W + TS2_SUB_W;

    ts2_ent_t         push_ent, rd_ent, head;
    logic             we;
    logic [PTR_W-1:0] waddr, raddr;
    logic [RAW_W-1:0] fid_raw;

    assign push_ent = '{tx: push_tx_i, port: push_port_i, nsec: push_nsec_i, subns: push_subns_i};

    ts2_store #(.DEPTH(DEPTH)) u_store (
        .clk_i   (clk_i),
        .we_i    (we),
        .waddr_i (waddr),
        .wdata_i (push_ent),
        .raddr_i (raddr),
        .rdata_o (rd_ent)
    );

    ts2_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .push_i     (push_i),
        .push_ent_i (push_ent),
        .next_i     (next_i),
        .ovf_clr_i  (ovf_clr_i),
        .rd_ent_i   (rd_ent),
        .we_o       (we),
        .waddr_o    (waddr),
        .raddr_o    (raddr),
        .valid_o    (head_valid_o),
        .ovf_o      (head_ovf_o),
        .head_o     (head)
    );

    assign head_tx_o    = head.tx;
    assign head_port_o  = head.port;
    assign head_nsec_o  = head.nsec;
    assign head_subns_o = head.subns;
    assign fid_raw      = {head.nsec, head.subns};
    assign head_fid_o   = fid_raw[FID_W-1:0];
    assign irq_o        = head_valid_o;

    initial begin
        AST_FID_WIDTH: assert (FID_W <= RAW_W && FID_W > 0); // R9
    end
endmodule

// File: tb/tb_ts2_fifo_top.sv
`timescale 1ns/1ps
module tb_ts2_fifo_top;
    import ts2_pkg::*;

    localparam int DEPTH = 32;
    localparam int FID_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push = 1'b0, p_tx = 1'b0, nxt = 1'b0, clr = 1'b0;
    logic [TS2_PORT_W-1:0] p_port = '0;
    logic [TS2_NS_W-1:0]   p_nsec = '0;
    logic [TS2_SUB_W-1:0]  p_sub = '0;
    logic h_valid, h_ovf, h_tx, irq;
    logic [TS2_PORT_W-1:0] h_port;
    logic [TS2_NS_W-1:0]   h_nsec;
    logic [TS2_SUB_W-1:0]  h_sub;
    logic [FID_W-1:0]      h_fid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    ts2_ent_t model_q[$];
    logic     model_ovf = 1'b0;

    always #2 clk = ~clk;

    ts2_fifo_top #(.DEPTH(DEPTH), .FID_W(FID_W)) dut (
        .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_tx_i(p_tx),
        .push_port_i(p_port), .push_nsec_i(p_nsec), .push_subns_i(p_sub),
        .next_i(nxt), .ovf_clr_i(clr), .head_valid_o(h_valid), .head_ovf_o(h_ovf),
        .head_tx_o(h_tx), .head_port_o(h_port), .head_nsec_o(h_nsec),
        .head_subns_o(h_sub), .head_fid_o(h_fid), .irq_o(irq)
    );

    function automatic logic [FID_W-1:0] exp_fid(input ts2_ent_t e);
        logic [TS2_NS_W+TS2_SUB_W-1:0] raw;
        raw = ({8'd0, e.nsec} << 8) | {{TS2_NS_W{1'b0}}, e.subns};
        return raw[FID_W-1:0];
    endfunction

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        ts2_ent_t e;
        logic     v;
        v = (model_q.size() != 0);
        e = v ? model_q[0] : '0;
        chk({tag, " R2"}, "valid", 64'(h_valid), 64'(v));
        chk({tag, " R7"}, "ovf", 64'(h_ovf), 64'(model_ovf));
        chk({tag, " R8"}, "irq", 64'(irq), 64'(v));
        chk({tag, " R10"}, "entry", 64'({h_tx, h_port, h_nsec, h_sub}), 64'(e));
        chk({tag, " R9"}, "fid", 64'(h_fid), 64'(exp_fid(e)));
    endtask

    // drive at a falling edge, model at the rising edge, compare at the next falling edge
    task automatic cyc(input logic ps, input ts2_ent_t e, input logic nx, input logic cl, input string tag);
        logic pop_ok, push_ok;
        push = ps; p_tx = e.tx; p_port = e.port; p_nsec = e.nsec; p_sub = e.subns;
        nxt = nx; clr = cl;
        @(posedge clk);
        pop_ok  = nx && (model_q.size() != 0);
        push_ok = ps && ((model_q.size() < DEPTH) || pop_ok);
        if (ps && !push_ok) model_ovf = 1'b1;
        else if (cl)        model_ovf = 1'b0;
        if (pop_ok)  void'(model_q.pop_front());
        if (push_ok) model_q.push_back(e);
        @(negedge clk);
        push = 0; nxt = 0; clr = 0;
        compare(tag);
    endtask

    function automatic ts2_ent_t rnd_ent();
        ts2_ent_t e;
        e.tx = 1'($urandom); e.port = TS2_PORT_W'($urandom);
        e.nsec = TS2_NS_W'($urandom); e.subns = TS2_SUB_W'($urandom);
        return e;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset");
        // R4: pop on empty queue
        cyc(0, '0, 1, 0, "R4 empty pop");
        cyc(1, '{1'b1, 7'd5, 30'h1234_5678, 8'hAB}, 1, 0, "R4 pop+push on empty");
        // R3: transmit entry followed by identifier entry, drained in order
        cyc(1, '{1'b0, 7'd0, 30'h0000_0012, 8'h34}, 0, 0, "R3 companion");
        cyc(0, '0, 1, 0, "R3 pop tx");
        cyc(0, '0, 1, 0, "R3 pop id");
        cyc(0, '0, 1, 0, "R3 pop to empty");
        // R5: overfill
        for (int i = 0; i < DEPTH + 3; i++) cyc(1, rnd_ent(), 0, 0, "R5 fill");
        // R6: push+pop on full
        cyc(1, rnd_ent(), 1, 0, "R6 full swap");
        // R7: clear, then clear racing a drop
        cyc(0, '0, 0, 1, "R7 clear");
        cyc(1, rnd_ent(), 0, 1, "R7 drop wins");
        cyc(0, '0, 0, 0, "R7 sticky");
        cyc(0, '0, 0, 1, "R7 clear again");
        for (int i = 0; i < DEPTH + 1; i++) cyc(0, '0, 1, 0, "R3 drain");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            int pp;
            pp = (i < 1500) ? 70 : ((i < 3000) ? 30 : 50);
            cyc(($urandom % 100) < pp, rnd_ent(), ($urandom % 100) < 50,
                ($urandom % 100) < 5, "R3 random");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule